// File: doc/BRIEF.md
# Three-Operand Multiply-Accumulate Unit

This block serves the integer pipeline of a 64-bit core. Each request supplies two multiplicand registers and the present value of the destination register. The destination value is the running accumulator. The unit returns the destination value plus or minus the product. A request can select one of three result widths:

- **Full:** a plain 64-bit result.
- **Word:** a 32-bit result sign-extended to 64 bits.
- **Halfword:** the multiplicands are first narrowed to sign-extended 16-bit values, and the sum is then narrowed to 32 bits and sign-extended.

Requests enter through a valid/ready handshake. Only one operation is in flight at a time. The multiplier is a register pipeline, and its depth is set by the latency parameter. The response is presented with a valid flag and is held until the consumer takes it. While a response retires, the unit can accept a new request in the same cycle.

Top module: `mac_unit`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0 and rsp_data_o is 0.
- R2: A request is taken on a rising edge where req_valid_i and req_ready_o are both 1. From that edge until its response retires, req_ready_o is 0, except in the retire cycle itself.
- R3: rsp_valid_o rises exactly LATENCY clock edges after the accepting edge (default 3). While rsp_valid_o is 1 and rsp_ready_i is 0, rsp_valid_o stays 1 and rsp_data_o holds its value.
- R4: req_op_i bit 0 selects subtract (1) or add (0). Bits 2:1 select the width: 00 full, 01 word, 10 halfword. Code 11 behaves like full width.
- R5: A full-width add returns the low 64 bits of rd + rs1*rs2, wrapping modulo 2^64.
- R6: A full-width subtract returns the low 64 bits of rd - rs1*rs2, wrapping modulo 2^64.
- R7: A word operation forms the full 64-bit sum or difference, keeps bits 31:0 and sign-extends bit 31 into bits 63:32. The upper bits of the operands matter only through that low word.
- R8: A halfword operation multiplies the sign-extended rs1[15:0] and rs2[15:0], adds the product to rd or subtracts it from rd, and sign-extends bit 31 of the result. Bits 63:16 of rs1 and rs2 have no effect.
- R9: A response retires on an edge where rsp_valid_o and rsp_ready_i are both 1. In that cycle req_ready_o is 1, so a new request can be taken on the same edge.
- R10: A request offered while an operation is outstanding is not taken. The outstanding result is unchanged, and that request produces no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Unit can take a request |
| req_op_i | input | 3 | Operation select: bit 0 subtract, bits 2:1 width |
| req_rs1_i | input | 64 | First multiplicand |
| req_rs2_i | input | 64 | Second multiplicand |
| req_rd_i | input | 64 | Accumulator (current destination value) |
| rsp_valid_o | output | 1 | Result available |
| rsp_ready_i | input | 1 | Consumer takes the result |
| rsp_data_o | output | 64 | Result |

## Verification
A response can retire on the same edge that a new request is accepted. In that cycle the ready output depends combinationally on the consumer's ready.

The bench provokes this in two ways:

- **Busy offer:** it holds a second request valid while the first is still in flight. It then checks that ready stays low, that the first result is unchanged, and that no extra response follows.
- **Back-to-back:** at the cycle the first response is shown, it raises the consumer's ready and offers a new operation together. It then checks that ready is high, and that the new result appears exactly LATENCY edges later with its own reference value.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    WID_FULL = 2'b00,
    WID_WORD = 2'b01,
    WID_HALF = 2'b10,
    WID_RSVD = 2'b11
  } mac_wid_e;

  typedef struct packed {
    mac_wid_e wid;
    logic     sub;
  } mac_op_t;
endpackage

// File: rtl/mac_operand_prep.sv
module mac_operand_prep
  import mac_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = 16
) (
  input  mac_op_t           op_i,
  input  logic [DATA_W-1:0] rs1_i,
  input  logic [DATA_W-1:0] rs2_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  localparam int EXT_W = DATA_W - HALF_W;

  always_comb begin
    if (op_i.wid == WID_HALF) begin
      a_o = {{EXT_W{rs1_i[HALF_W-1]}}, rs1_i[HALF_W-1:0]};
      b_o = {{EXT_W{rs2_i[HALF_W-1]}}, rs2_i[HALF_W-1:0]};
    end else begin
      a_o = rs1_i;
      b_o = rs2_i;
    end
  end
endmodule

// File: rtl/mac_mult_pipe.sv
module mac_mult_pipe #(
  parameter int DATA_W = 64,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] p_o
);
  logic [DATA_W-1:0] prod;
  logic [DATA_W-1:0] stg_q [STAGES];

  // low half of the product only; stages give retiming room
  assign prod = a_i * b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= prod;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign p_o = stg_q[STAGES-1];
endmodule

// File: rtl/mac_result_fmt.sv
module mac_result_fmt
  import mac_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  mac_op_t           op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] prod_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int EXT_W = DATA_W - WORD_W;

  logic [DATA_W-1:0] sum;
  logic              narrow;

  assign sum    = op_i.sub ? (acc_i - prod_i) : (acc_i + prod_i);
  assign narrow = (op_i.wid == WID_WORD) || (op_i.wid == WID_HALF);
  assign res_o  = narrow ? {{EXT_W{sum[WORD_W-1]}}, sum[WORD_W-1:0]} : sum;
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int WORD_W  = 32,
  parameter int HALF_W  = 16,
  parameter int LATENCY = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_op_i,
  input  logic [DATA_W-1:0] req_rs1_i,
  input  logic [DATA_W-1:0] req_rs2_i,
  input  logic [DATA_W-1:0] req_rd_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o
);
  localparam int                STAGES = LATENCY - 1;
  localparam int                CNT_W  = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0]  CNT_END = CNT_W'(LATENCY);

  mac_op_t           op_q;
  logic [DATA_W-1:0] rs1_q, rs2_q, rd_q;
  logic              busy_q, rsp_valid_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [DATA_W-1:0] mul_a, mul_b, prod, res;
  logic              accept, retire;

  assign retire      = rsp_valid_q & rsp_ready_i;
  assign req_ready_o = ~busy_q | retire;
  assign accept      = req_valid_i & req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q        <= '{wid: WID_FULL, sub: 1'b0};
      rs1_q       <= '0;
      rs2_q       <= '0;
      rd_q        <= '0;
      busy_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      cnt_q       <= '0;
      rsp_data_q  <= '0;
    end else if (accept) begin
      op_q        <= mac_op_t'(req_op_i);
      rs1_q       <= req_rs1_i;
      rs2_q       <= req_rs2_i;
      rd_q        <= req_rd_i;
      busy_q      <= 1'b1;
      rsp_valid_q <= 1'b0;
      cnt_q       <= CNT_W'(1);
    end else if (retire) begin
      busy_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
    end else if (busy_q && !rsp_valid_q) begin
      if (cnt_q == CNT_END) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= res;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  mac_operand_prep #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_prep (
    .op_i (op_q),
    .rs1_i(rs1_q),
    .rs2_i(rs2_q),
    .a_o  (mul_a),
    .b_o  (mul_b)
  );

  mac_mult_pipe #(.DATA_W(DATA_W), .STAGES(STAGES)) u_mul (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (mul_a),
    .b_i   (mul_b),
    .p_o   (prod)
  );

  mac_result_fmt #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_fmt (
    .op_i  (op_q),
    .acc_i (rd_q),
    .prod_i(prod),
    .res_o (res)
  );

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int DATA_W  = 64,
  parameter int WORD_W  = 32,
  parameter int LATENCY = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [1:0]        op_wid_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [DATA_W-1:0] rsp_data_o
);
  localparam int               AW    = $clog2(LATENCY + 2);
  localparam logic [AW-1:0]    LAT_V = AW'(LATENCY);
  localparam logic [AW-1:0]    TOP_V = AW'(LATENCY + 1);

  logic [AW-1:0] age_q;
  logic          narrow_q;
  logic          acc, ret;

  assign acc = req_valid_i & req_ready_o;
  assign ret = rsp_valid_o & rsp_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q    <= '0;
      narrow_q <= 1'b0;
    end else if (acc) begin
      age_q    <= AW'(1);
      narrow_q <= (op_wid_i == 2'b01) || (op_wid_i == 2'b10);
    end else if (ret) begin
      age_q <= '0;
    end else if (age_q != '0 && age_q != TOP_V) begin
      age_q <= age_q + AW'(1);
    end
  end

  a_r2_no_ready_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != '0 && !rsp_valid_o) |-> !req_ready_o);

  a_r3_quiet_before_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != '0 && age_q <= LAT_V) |-> !rsp_valid_o);

  a_r3_valid_at_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == TOP_V) |-> rsp_valid_o);

  a_r3_hold_until_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));

  a_r9_ready_on_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_ready_i) |-> req_ready_o);

  // R7, R8: narrow results are sign-extended from bit WORD_W-1
  a_r7_narrow_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && narrow_q) |->
      (rsp_data_o[DATA_W-1:WORD_W] == {(DATA_W-WORD_W){rsp_data_o[WORD_W-1]}}));
endmodule

bind mac_unit mac_unit_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W), .LATENCY(LATENCY)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .op_wid_i   (req_op_i[2:1]),
  .rsp_valid_o(rsp_valid_o),
  .rsp_ready_i(rsp_ready_i),
  .rsp_data_o (rsp_data_o)
);

// File: tb/mac_unit_tb.sv
module mac_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [2:0]  req_op_i = '0;
  logic [63:0] req_rs1_i = '0, req_rs2_i = '0, req_rd_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic [63:0] rsp_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mac_unit #(.LATENCY(LAT)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_op_i(req_op_i),
    .req_rs1_i(req_rs1_i), .req_rs2_i(req_rs2_i), .req_rd_i(req_rd_i),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_data_o(rsp_data_o)
  );

  // reference from R4..R8
  function automatic logic [63:0] ref_mac(logic [2:0] op, logic [63:0] a, logic [63:0] b,
                                          logic [63:0] c);
    logic [63:0] x, y, p, s;
    x = a; y = b;
    if (op[2:1] == 2'b10) begin
      x = {{48{a[15]}}, a[15:0]};
      y = {{48{b[15]}}, b[15:0]};
    end
    p = x * y;
    s = op[0] ? c - p : c + p;
    if (op[2:1] == 2'b01 || op[2:1] == 2'b10) s = {{32{s[31]}}, s[31:0]};
    return s;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a negedge, accept on next posedge, return at following negedge
  task automatic issue(logic [2:0] op, logic [63:0] a, logic [63:0] b, logic [63:0] c);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = op; req_rs1_i = a; req_rs2_i = b; req_rd_i = c;
    #1 chk("R2 ready before accept", 64'(req_ready_o), 64'd1);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  // called at negedge right after accept; leaves at negedge where valid is seen
  task automatic wait_rsp(string req, logic [63:0] exp);
    for (int k = 0; k < LAT; k++) begin
      chk("R3 valid low before latency", 64'(rsp_valid_o), 64'd0);
      @(negedge clk_i);
    end
    chk("R3 valid at latency", 64'(rsp_valid_o), 64'd1);
    chk(req, rsp_data_o, exp);
  endtask

  task automatic retire();
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    #1 chk("R9 valid drops after retire", 64'(rsp_valid_o), 64'd0);
  endtask

  task automatic run(string req, logic [2:0] op, logic [63:0] a, logic [63:0] b,
                     logic [63:0] c);
    issue(op, a, b, c);
    wait_rsp(req, ref_mac(op, a, b, c));
    retire();
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", 64'(req_ready_o), 64'd1);
    chk("R1 valid after reset", 64'(rsp_valid_o), 64'd0);
    chk("R1 data after reset", rsp_data_o, 64'd0);
  endtask

  task automatic t_full();
    run("R5 add basic", 3'b000, 64'd7, 64'd6, 64'd100);
    issue(3'b000, 64'd1, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    wait_rsp("R5 add wrap to zero", 64'd0);
    retire();
    run("R5 most negative times -1", 3'b000, 64'h8000_0000_0000_0000,
        64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    run("R5 large product", 3'b000, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3211,
        64'h1111_2222_3333_4444);
    issue(3'b001, 64'd1, 64'd1, 64'd0);
    wait_rsp("R6 sub wrap below zero", 64'hFFFF_FFFF_FFFF_FFFF);
    retire();
    run("R6 sub large", 3'b001, 64'hDEAD_BEEF_0000_0001, 64'd3, 64'h0F0F_0F0F_0F0F_0F0F);
  endtask

  task automatic t_word();
    issue(3'b010, 64'h7FFF_FFFF, 64'd1, 64'd0);
    wait_rsp("R7 word positive", 64'h0000_0000_7FFF_FFFF);
    retire();
    issue(3'b010, 64'h8000_0000, 64'd1, 64'd0);
    wait_rsp("R7 word sign bit", 64'hFFFF_FFFF_8000_0000);
    retire();
    issue(3'b010, 64'h0000_0001_0000_0001, 64'd3, 64'hFFFF_0000_0000_0000);
    wait_rsp("R7 word drops upper bits", 64'd3);
    retire();
    run("R7 word sub", 3'b011, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321,
        64'h5555_AAAA_5555_AAAA);
  endtask

  task automatic t_half();
    issue(3'b100, 64'hDEAD_0000_0000_8000, 64'h1234_5678_9ABC_8000, 64'h4000_0000);
    wait_rsp("R8 half most negative square", 64'hFFFF_FFFF_8000_0000);
    retire();
    issue(3'b101, 64'hAAAA_BBBB_CCCC_FFFF, 64'h7777_0000_0000_0002, 64'd0);
    wait_rsp("R8 half sub of negative", 64'd2);
    retire();
    run("R8 half mixed", 3'b100, 64'hFFFF_FFFF_FFFF_7FFF, 64'h0000_0000_0001_7FFF,
        64'h0000_0001_0000_0000);
  endtask

  task automatic t_rsvd();
    run("R4 reserved width add", 3'b110, 64'h1_0000_0003, 64'h1_0000_0005, 64'd9);
    run("R4 reserved width sub", 3'b111, 64'h1_0000_0003, 64'h1_0000_0005, 64'd9);
  endtask

  task automatic t_hold();
    logic [63:0] first;
    issue(3'b000, 64'd11, 64'd13, 64'd5);
    wait_rsp("R3 hold result", 64'd148);
    first = rsp_data_o;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk("R3 valid held", 64'(rsp_valid_o), 64'd1);
      chk("R3 data held", rsp_data_o, first);
    end
    retire();
  endtask

  task automatic t_busy();
    issue(3'b000, 64'd2, 64'd3, 64'd4);
    req_valid_i = 1'b1; req_op_i = 3'b001; req_rs1_i = 64'd50; req_rs2_i = 64'd50;
    req_rd_i = 64'd1;
    for (int k = 0; k < LAT; k++) begin
      #1 chk("R2 ready low while busy", 64'(req_ready_o), 64'd0);
      @(negedge clk_i);
    end
    chk("R10 outstanding result kept", rsp_data_o, 64'd10);
    chk("R2 ready low while result waits", 64'(req_ready_o), 64'd0);
    req_valid_i = 1'b0;
    retire();
    for (int k = 0; k < LAT + 2; k++) begin
      @(negedge clk_i);
      chk("R10 no response for ignored request", 64'(rsp_valid_o), 64'd0);
    end
  endtask

  task automatic t_b2b();
    issue(3'b010, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 64'd0);
    wait_rsp("R9 first of pair", 64'd1);
    rsp_ready_i = 1'b1;
    req_valid_i = 1'b1; req_op_i = 3'b101; req_rs1_i = 64'h0003; req_rs2_i = 64'hFFFB;
    req_rd_i = 64'd100;
    #1 chk("R9 ready during retire", 64'(req_ready_o), 64'd1);
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    req_valid_i = 1'b0;
    wait_rsp("R9 second of pair", 64'd115);
    retire();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1 t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_full();
    t_word();
    t_half();
    t_rsvd();
    t_hold();
    t_busy();
    t_b2b();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule